// File: doc/BRIEF.md
# Local-to-PCI Address Window Translator

This block sits between a local bus and a PCI host interface and decides, for each local access, whether it falls into one of the outbound windows that software has set up. The block keeps three windows. Windows 0 and 1 serve memory accesses, and window 2 serves I/O accesses. Each window is described by three registers: a base, a range mask, and a remap word. The remap word carries the PCI-side base together with two control bits.

The block takes one request per cycle. Each request carries an address and a memory/I/O flag. One clock later the block returns four things:
- a hit flag,
- the index of the winning window,
- the translated PCI address,
- a segment select that chooses the PCI segment or the CardBus segment.

Software programs the windows through a write-only port. Each write names a window and a field. A single I/O window serves both downstream segments. Software moves it from one segment to the other by rewriting the routing bit in the I/O window's remap word.

Top module: `addr_xlate`

## Requirements
- R1: After reset every window is disabled, so every request misses.
- R2: Base, range and remap registers keep only address bits 31:15. Bits 14:0 of the write data are dropped for the address part, so a base written as 0x1000_7FFF acts as 0x1000_0000.
- R3: A window hits when (request address AND range) equals its base on bits 31:15. The range register holds the inverse of (window size − 1).
- R4: Remap bit 0 enables the window. A disabled window never hits.
- R5: The translated address is (remap base AND range) OR (request address AND NOT range). Bits 14:0 of the request address always pass through unchanged.
- R6: Remap bit 2 set drives resp_cb_o high for hits in that window, which routes the access to CardBus. When the bit is clear, the access goes to PCI.
- R7: When both memory windows hit, window 0 wins.
- R8: A request with req_io_i=1 can hit only window 2. A request with req_io_i=0 can hit only windows 0 and 1.
- R9: A write takes effect for requests sampled on the next clock edge. A request sampled on the same edge as a write sees the old value.
- R10: resp_valid_o follows req_valid_i by exactly one cycle. On a miss, resp_addr_o, resp_win_o and resp_cb_o are 0.
- R11: Rewriting the routing bit of window 2 moves I/O ownership between segments. Later I/O hits follow the new setting.
- R12: The write port uses wr_field_i = 0 for the base, 1 for the range and 2 for the remap word, and wr_win_i selects window 0–2. A field code of 3 or a window index of 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_win_i | input | 2 | Window index of the write |
| wr_field_i | input | 2 | Field of the write: 0 base, 1 range, 2 remap |
| wr_data_i | input | 32 | Write data |
| req_valid_i | input | 1 | Request valid |
| req_addr_i | input | 32 | Local address of the request |
| req_io_i | input | 1 | 1 = I/O request, 0 = memory request |
| resp_valid_o | output | 1 | Response valid, one cycle after the request |
| resp_hit_o | output | 1 | A window matched |
| resp_win_o | output | 2 | Index of the winning window |
| resp_addr_o | output | 32 | Translated PCI address |
| resp_cb_o | output | 1 | 1 = CardBus segment, 0 = PCI segment |

## Verification
Every fault in the window registers becomes visible on the response one cycle after the next request that probes that window. The symptoms depend on which register is wrong:
- A wrong base or range shows up as a false hit or a false miss.
- A stale remap base shows up as wrong upper translated bits.
- A lost enable or routing bit flips resp_hit_o or resp_cb_o.

Errors in priority or in the I/O/memory split only show when several windows overlap. For that reason the directed tests place overlapping windows on purpose and probe them with both request types. Write timing is checked by issuing a write and a request on the same edge.

// File: rtl/addr_xlate_pkg.sv
package addr_xlate_pkg;
  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_RANGE = 2'd1,
    FLD_REMAP = 2'd2,
    FLD_NONE  = 2'd3
  } fld_e;

  localparam int unsigned REMAP_EN_BIT = 0;
  localparam int unsigned REMAP_CB_BIT = 2;
endpackage

// File: rtl/axl_window.sv
module axl_window
  import addr_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LSB    = 15,
  parameter int unsigned WIN_W  = 2,
  parameter int unsigned IDX    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WIN_W-1:0]  wr_win_i,
  input  logic [1:0]        wr_field_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              match_o,
  output logic              en_o,
  output logic              cb_o,
  output logic [ADDR_W-1:0] xaddr_o
);
  localparam int unsigned HW = ADDR_W - LSB;

  logic [HW-1:0] base_q, range_q, remap_q;
  logic          en_q, cb_q;
  logic          sel;

  assign sel = wr_en_i && (wr_win_i == WIN_W'(IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      range_q <= '0;
      remap_q <= '0;
      en_q    <= 1'b0;
      cb_q    <= 1'b0;
    end else if (sel) begin
      case (fld_e'(wr_field_i))
        FLD_BASE:  base_q  <= wr_data_i[ADDR_W-1:LSB];
        FLD_RANGE: range_q <= wr_data_i[ADDR_W-1:LSB];
        FLD_REMAP: begin
          remap_q <= wr_data_i[ADDR_W-1:LSB];
          en_q    <= wr_data_i[REMAP_EN_BIT];
          cb_q    <= wr_data_i[REMAP_CB_BIT];
        end
        default: ;
      endcase
    end
  end

  assign match_o = en_q && ((addr_i[ADDR_W-1:LSB] & range_q) == base_q);
  assign en_o    = en_q;
  assign cb_o    = cb_q;
  assign xaddr_o = {(remap_q & range_q) | (addr_i[ADDR_W-1:LSB] & ~range_q),
                    addr_i[LSB-1:0]};

  // R4/R6: remap write lands control bits on the next cycle
  a_r4_remap_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && wr_field_i == 2'd2) |=> (en_q == $past(wr_data_i[REMAP_EN_BIT]) &&
                                     cb_q == $past(wr_data_i[REMAP_CB_BIT])));
  // R12: unused field code leaves state untouched
  a_r12_no_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_field_i == 2'd3) |=> ($stable(base_q) && $stable(range_q) &&
                                         $stable(remap_q) && $stable(en_q)));
endmodule

// File: rtl/axl_pick.sv
module axl_pick #(
  parameter int unsigned N     = 3,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;

  // R7: chosen index is a requester with nothing lower requesting
  always_comb begin
    if (any_o) begin
      a_r7_lowest_wins: assert (req_i[idx_o] &&
                                ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LSB    = 15,
  parameter int unsigned N_MEM  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_win_i,
  input  logic [1:0]        wr_field_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_io_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [1:0]        resp_win_o,
  output logic [ADDR_W-1:0] resp_addr_o,
  output logic              resp_cb_o
);
  localparam int unsigned NW     = N_MEM + 1;
  localparam int unsigned WIN_W  = 2;
  localparam int unsigned IO_IDX = NW - 1;

  logic [NW-1:0]     match, elig, en_vec, cb_vec;
  logic [ADDR_W-1:0] xaddr [NW];
  logic              any;
  logic [WIN_W-1:0]  idx;

  for (genvar w = 0; w < NW; w++) begin : g_win
    axl_window #(.ADDR_W(ADDR_W), .LSB(LSB), .WIN_W(WIN_W), .IDX(w)) u_win (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_win_i  (wr_win_i),
      .wr_field_i(wr_field_i),
      .wr_data_i (wr_data_i),
      .addr_i    (req_addr_i),
      .match_o   (match[w]),
      .en_o      (en_vec[w]),
      .cb_o      (cb_vec[w]),
      .xaddr_o   (xaddr[w])
    );
    // I/O window answers only I/O requests, memory windows only memory
    if (w == IO_IDX) begin : g_io
      assign elig[w] = match[w] && req_io_i;
    end else begin : g_mem
      assign elig[w] = match[w] && !req_io_i;
    end
  end

  axl_pick #(.N(NW), .IDX_W(WIN_W)) u_pick (
    .req_i(elig),
    .any_o(any),
    .idx_o(idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_win_o   <= '0;
      resp_addr_o  <= '0;
      resp_cb_o    <= 1'b0;
    end else begin
      resp_valid_o <= req_valid_i;
      if (req_valid_i && any) begin
        resp_hit_o  <= 1'b1;
        resp_win_o  <= idx;
        resp_addr_o <= xaddr[idx];
        resp_cb_o   <= cb_vec[idx];
      end else begin
        resp_hit_o  <= 1'b0;
        resp_win_o  <= '0;
        resp_addr_o <= '0;
        resp_cb_o   <= 1'b0;
      end
    end
  end

  a_r10_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);
  a_r10_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_hit_o) |-> (resp_addr_o == '0 && !resp_cb_o && resp_win_o == '0));
  a_r8_space_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && any) |=> (resp_hit_o &&
      ((resp_win_o == WIN_W'(IO_IDX)) == $past(req_io_i))));
  a_r4_enabled_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && en_vec == '0) |=> !resp_hit_o);
endmodule

// File: tb/sim_addr_xlate.sv
module sim_addr_xlate;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_win_i = '0;
  logic [1:0]  wr_field_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_io_i = 1'b0;
  logic        resp_valid_o, resp_hit_o, resp_cb_o;
  logic [1:0]  resp_win_o;
  logic [31:0] resp_addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  addr_xlate u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_win_i(wr_win_i), .wr_field_i(wr_field_i), .wr_data_i(wr_data_i),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_io_i(req_io_i),
    .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o), .resp_win_o(resp_win_o),
    .resp_addr_o(resp_addr_o), .resp_cb_o(resp_cb_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] win, input logic [1:0] fld, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_win_i = win; wr_field_i = fld; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic io,
                       input logic hit, input logic [1:0] win,
                       input logic [31:0] xa, input logic cb);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_io_i = io;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({req, " valid"}, 64'(resp_valid_o), 64'(1'b1));
    chk({req, " hit"},   64'(resp_hit_o),   64'(hit));
    chk({req, " win"},   64'(resp_win_o),   64'(win));
    chk({req, " addr"},  64'(resp_addr_o),  64'(xa));
    chk({req, " cb"},    64'(resp_cb_o),    64'(cb));
  endtask

  task automatic t_reset;
    chk("R1 reset valid", 64'(resp_valid_o), 64'(1'b0));
    probe("R1 mem miss", 32'h1000_0000, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0);
    probe("R1 io miss",  32'h0000_0000, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0);
  endtask

  task automatic t_win0;
    wr(2'd0, 2'd0, 32'h1000_7FFF);
    wr(2'd0, 2'd1, 32'hFFF0_0000);
    wr(2'd0, 2'd2, 32'h4000_0001);
    probe("R2 R3 R5 win0 hit", 32'h1002_3456, 1'b0, 1'b1, 2'd0, 32'h4002_3456, 1'b0);
    probe("R3 win0 miss", 32'h1010_0000, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0);
    @(negedge clk_i);
    chk("R10 idle valid low", 64'(resp_valid_o), 64'(1'b0));
  endtask

  task automatic t_overlap;
    wr(2'd1, 2'd0, 32'h1008_0000);
    wr(2'd1, 2'd1, 32'hFFF8_0000);
    wr(2'd1, 2'd2, 32'h8000_0005);
    probe("R7 win0 priority", 32'h1008_1234, 1'b0, 1'b1, 2'd0, 32'h4008_1234, 1'b0);
    wr(2'd0, 2'd2, 32'h4000_0000);
    probe("R4 R6 win1 after disable", 32'h1008_1234, 1'b0, 1'b1, 2'd1, 32'h8000_1234, 1'b1);
    probe("R4 win0 disabled miss", 32'h1002_3456, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0);
  endtask

  task automatic t_io;
    wr(2'd2, 2'd0, 32'h0000_8000);
    wr(2'd2, 2'd1, 32'hFFFF_8000);
    wr(2'd2, 2'd2, 32'h2000_0001);
    probe("R8 io hit", 32'h0000_8010, 1'b1, 1'b1, 2'd2, 32'h2000_0010, 1'b0);
    probe("R8 mem no io window", 32'h0000_8010, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0);
    probe("R8 io no mem window", 32'h1008_1234, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0);
  endtask

  task automatic t_owner;
    wr(2'd2, 2'd2, 32'h2000_0005);
    probe("R11 io to cardbus", 32'h0000_8020, 1'b1, 1'b1, 2'd2, 32'h2000_0020, 1'b1);
    wr(2'd2, 2'd2, 32'h2000_0001);
    probe("R11 io back to pci", 32'h0000_8020, 1'b1, 1'b1, 2'd2, 32'h2000_0020, 1'b0);
  endtask

  task automatic t_ignored;
    wr(2'd1, 2'd3, 32'h0000_0000);
    wr(2'd3, 2'd2, 32'h0000_0000);
    probe("R12 win1 unchanged", 32'h1008_0040, 1'b0, 1'b1, 2'd1, 32'h8000_0040, 1'b1);
    probe("R12 io unchanged", 32'h0000_8004, 1'b1, 1'b1, 2'd2, 32'h2000_0004, 1'b0);
  endtask

  task automatic t_same_edge;
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_win_i = 2'd2; wr_field_i = 2'd2; wr_data_i = 32'h2000_0000;
    req_valid_i = 1'b1; req_addr_i = 32'h0000_8008; req_io_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; req_valid_i = 1'b0;
    chk("R9 same edge old value hit", 64'(resp_hit_o), 64'(1'b1));
    chk("R9 same edge old addr", 64'(resp_addr_o), 64'(32'h2000_0008));
    probe("R9 next edge new value", 32'h0000_8008, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_win0();
    t_overlap();
    t_io();
    t_owner();
    t_ignored();
    t_same_edge();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule